// File: doc/BRIEF.md
# Black-Level Offset Calibration Controller

This block closes a digital feedback loop around the front end of an image sensor. While the timing generator holds the calibration enable high during rows of shielded (dark) pixels, the block waits for each converter result and compares it with a programmable dark-level target. It then moves an 8-bit offset-DAC code one step toward the target. After many such steps the converter reads the chosen dark code for a black input. When the enable drops, the DAC code stays where it is for the active pixels.

A fixed phase counter sets the timing, one phase per pixel clock. Phase 0 is idle and phase 1 lets the analog path settle. Phase 2 samples the pixel, and phases 3, 4 and 5 cover the conversion. In phase 6 the result is compared with the target, and in phase 7 the new code is presented to the DAC. The counter then runs from phase 7 back to phase 2. The first correction after enable therefore takes eight clocks and each one after it takes six. While calibration is off, a host may load the DAC code directly. The dark target also has its own write port.

Top module: `blc_cal_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the DAC code is 128, the update strobe is low and the dark target is 32.
- R2: With the DAC code at 128 and the target at its reset value of 32, counting the clock in which the enable is first sampled high as cycle 1, the update strobe is high in cycle 8. It is therefore seen on the 7th falling edge after the enable is raised.
- R3: After each update, while the enable stays high, the phases run 2,3,4,5,6,7 again. Strobes are therefore exactly 6 clocks apart and each strobe lasts one clock.
- R4: If the sampled converter code is above the target, the DAC code falls by 1. The new value appears in the same clock as the strobe.
- R5: If the sampled converter code is below the target, the DAC code rises by 1.
- R6: If the sampled converter code equals the target, the DAC code is unchanged. The strobe still occurs.
- R7: The DAC code stops at 0 and at 255 and never wraps.
- R8: While the enable is low and no host write is made, the DAC code holds. Dropping the enable part way through a correction cancels that correction. The next enable again takes 8 clocks to the first strobe.
- R9: A host write loads the DAC code on the next clock only while the enable is low. A host write made while the enable is high has no effect.
- R10: The converter code is captured only on the clock edge that moves the phase from 5 to 6. Its value in every other cycle has no effect.
- R11: A write to the target port replaces the dark target. Later comparisons use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Calibration enable, high during dark-pixel readout |
| adc_code | input | 10 | Converter result |
| tgt_wr_en | input | 1 | Load strobe for the dark target |
| tgt_wr_data | input | 10 | New dark target |
| dac_wr_en | input | 1 | Host load strobe for the DAC code |
| dac_wr_data | input | 8 | Host DAC code |
| dac_code | output | 8 | Offset-DAC code |
| dac_upd | output | 1 | One-clock strobe marking a new DAC code |

## Verification
A phase counter that slips by even one state moves the strobe away from its 8-clock or 6-clock slot. The per-cycle comparison catches this on the first strobe after enable. A wrong comparison sign or a missing clamp shows as a DAC code one step off, visible in the strobe cycle. A capture made in the wrong phase shows once the bench changes the converter input outside phase 5, which it does, within one correction. A leak of host writes or of the enable gating shows as a code change in a cycle with no strobe, on the next clock.

// File: rtl/blc_pkg.sv
package blc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETTLE  = 3'd1,
    PH_SAMPLE  = 3'd2,
    PH_CONV0   = 3'd3,
    PH_CONV1   = 3'd4,
    PH_CONV2   = 3'd5,
    PH_COMPARE = 3'd6,
    PH_UPDATE  = 3'd7
  } phase_e;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;

  // Direction of the correction: a reading above target lowers the offset.
  function automatic dir_e step_dir(input int sample, input int target);
    if (sample > target)      return DIR_DOWN;
    else if (sample < target) return DIR_UP;
    else                      return DIR_HOLD;
  endfunction

  // Saturating one-step move of an unsigned code bounded by max_code.
  function automatic int step_code(input int code, input dir_e dir, input int max_code);
    case (dir)
      DIR_UP:   return (code >= max_code) ? max_code : code + 1;
      DIR_DOWN: return (code <= 0) ? 0 : code - 1;
      default:  return code;
    endcase
  endfunction

endpackage

// File: rtl/blc_phase_seq.sv
module blc_phase_seq
  import blc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  output phase_e phase,
  output logic   latch_now,
  output logic   apply_now
);

  phase_e phase_nxt;

  always_comb begin
    if (!en) begin
      phase_nxt = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:    phase_nxt = PH_SETTLE;
        PH_SETTLE:  phase_nxt = PH_SAMPLE;
        PH_SAMPLE:  phase_nxt = PH_CONV0;
        PH_CONV0:   phase_nxt = PH_CONV1;
        PH_CONV1:   phase_nxt = PH_CONV2;
        PH_CONV2:   phase_nxt = PH_COMPARE;
        PH_COMPARE: phase_nxt = PH_UPDATE;
        default:    phase_nxt = PH_SAMPLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end

  assign latch_now = en && (phase == PH_CONV2);
  assign apply_now = en && (phase == PH_COMPARE);

endmodule

// File: rtl/blc_target_reg.sv
module blc_target_reg #(
  parameter int ADC_W     = 10,
  parameter int TGT_RESET = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADC_W-1:0] wr_data,
  output logic [ADC_W-1:0] target
);

  localparam logic [ADC_W-1:0] RST_VAL = ADC_W'(TGT_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     target <= RST_VAL;
    else if (wr_en) target <= wr_data;
  end

endmodule

// File: rtl/blc_dac_accum.sv
module blc_dac_accum
  import blc_pkg::*;
#(
  parameter int ADC_W     = 10,
  parameter int DAC_W     = 8,
  parameter int DAC_RESET = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             latch_now,
  input  logic             apply_now,
  input  logic [ADC_W-1:0] adc_code,
  input  logic [ADC_W-1:0] target,
  input  logic             host_wr,
  input  logic [DAC_W-1:0] host_data,
  output logic [DAC_W-1:0] dac_code
);

  localparam int               DAC_MAX = (1 << DAC_W) - 1;
  localparam logic [DAC_W-1:0] RST_VAL = DAC_W'(DAC_RESET);

  logic [ADC_W-1:0] sample;
  dir_e             dir;
  logic [DAC_W-1:0] stepped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sample <= '0;
    else if (latch_now) sample <= adc_code;
  end

  assign dir     = step_dir(int'(sample), int'(target));
  assign stepped = DAC_W'(step_code(int'(dac_code), dir, DAC_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               dac_code <= RST_VAL;
    else if (apply_now)       dac_code <= stepped;
    else if (!en && host_wr)  dac_code <= host_data;
  end

endmodule

// File: rtl/blc_cal_ctrl.sv
module blc_cal_ctrl
  import blc_pkg::*;
#(
  parameter int ADC_W     = 10,
  parameter int DAC_W     = 8,
  parameter int TGT_RESET = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_en,
  input  logic [ADC_W-1:0] adc_code,
  input  logic             tgt_wr_en,
  input  logic [ADC_W-1:0] tgt_wr_data,
  input  logic             dac_wr_en,
  input  logic [DAC_W-1:0] dac_wr_data,
  output logic [DAC_W-1:0] dac_code,
  output logic             dac_upd
);

  localparam int DAC_MID = 1 << (DAC_W - 1);

  phase_e           phase;
  logic             latch_now;
  logic             apply_now;
  logic [ADC_W-1:0] target;

  blc_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cal_en),
    .phase     (phase),
    .latch_now (latch_now),
    .apply_now (apply_now)
  );

  blc_target_reg #(.ADC_W(ADC_W), .TGT_RESET(TGT_RESET)) u_tgt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tgt_wr_en),
    .wr_data (tgt_wr_data),
    .target  (target)
  );

  blc_dac_accum #(.ADC_W(ADC_W), .DAC_W(DAC_W), .DAC_RESET(DAC_MID)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cal_en),
    .latch_now (latch_now),
    .apply_now (apply_now),
    .adc_code  (adc_code),
    .target    (target),
    .host_wr   (dac_wr_en),
    .host_data (dac_wr_data),
    .dac_code  (dac_code)
  );

  assign dac_upd = (phase == PH_UPDATE);

endmodule

// File: rtl/blc_cal_checker.sv
module blc_cal_checker #(
  parameter int DAC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cal_en,
  input logic             dac_wr_en,
  input logic [DAC_W-1:0] dac_code,
  input logic             dac_upd,
  input logic [2:0]       phase
);

  localparam logic [DAC_W-1:0] MID = DAC_W'(1 << (DAC_W - 1));

  // R1: reset drives the code to mid-scale
  a_r1_reset_mid: assert property (@(posedge clk) !rst_n |=> dac_code == MID);

  // R3: after the update phase the sequence restarts at the sample phase
  a_r3_loop_to_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7 && cal_en) |=> phase == 3'd2);

  // R3: strobe lasts a single clock
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    dac_upd |=> !dac_upd);

  // R4: while calibrating, the code moves only together with the strobe
  a_r4_move_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cal_en |=> ($stable(dac_code) || dac_upd));

  // R7: a calibration step never moves by more than one, and never wraps
  a_r7_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    cal_en |=> ((int'(dac_code) - int'($past(dac_code))) <= 1 &&
                (int'($past(dac_code)) - int'(dac_code)) <= 1));

  // R8: with calibration off and no host write the code holds
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_en && !dac_wr_en) |=> $stable(dac_code));

endmodule

bind blc_cal_ctrl blc_cal_checker #(.DAC_W(DAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cal_en    (cal_en),
  .dac_wr_en (dac_wr_en),
  .dac_code  (dac_code),
  .dac_upd   (dac_upd),
  .phase     (phase)
);

// File: tb/blc_cal_ctrl_test.sv
module blc_cal_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cal_en = 1'b0;
  logic [9:0] adc_code = '0;
  logic       tgt_wr_en = 1'b0;
  logic [9:0] tgt_wr_data = '0;
  logic       dac_wr_en = 1'b0;
  logic [7:0] dac_wr_data = '0;
  logic [7:0] dac_code;
  logic       dac_upd;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_ph = 0, m_dac = 128, m_tgt = 32, m_smp = 0;

  always #4 clk = ~clk;

  blc_cal_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .adc_code(adc_code),
    .tgt_wr_en(tgt_wr_en), .tgt_wr_data(tgt_wr_data),
    .dac_wr_en(dac_wr_en), .dac_wr_data(dac_wr_data),
    .dac_code(dac_code), .dac_upd(dac_upd)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_dac = 128; m_tgt = 32; m_smp = 0;
    end else begin
      int nph;
      nph = !cal_en ? 0 : (m_ph == 7 ? 2 : m_ph + 1);
      if (cal_en && m_ph == 6) begin
        if (m_smp > m_tgt && m_dac > 0) m_dac = m_dac - 1;
        else if (m_smp < m_tgt && m_dac < 255) m_dac = m_dac + 1;
      end else if (!cal_en && dac_wr_en) begin
        m_dac = dac_wr_data;
      end
      if (cal_en && m_ph == 5) m_smp = adc_code;
      if (tgt_wr_en) m_tgt = tgt_wr_data;
      m_ph = nph;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock, then compare against the reference at the falling edge
  task automatic step();
    @(negedge clk);
    check(int'(dac_code) == m_dac, cur_req, dac_code, m_dac);
    check(dac_upd == (m_ph == 7), cur_req, dac_upd, (m_ph == 7));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // clocks until the strobe is seen (limit 40)
  task automatic wait_upd(output int n);
    n = 0;
    do begin step(); n++; end while (!dac_upd && n < 40);
  endtask

  task automatic host_load(input int v);
    dac_wr_en = 1'b1; dac_wr_data = 8'(v);
    step();
    dac_wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    int v0;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(dac_code == 8'd128, "R1", dac_code, 128);
    check(dac_upd == 1'b0, "R1", dac_upd, 0);
    rst_n = 1'b1;
    run(2);

    // R2/R4: default target 32, reading 40 -> first strobe after 8 clocks, step down
    cur_req = "R2"; adc_code = 10'd40; cal_en = 1'b1;
    wait_upd(n);
    check(n == 7, "R2", n, 7);
    check(dac_code == 8'd127, "R4", dac_code, 127);
    cur_req = "R3";
    wait_upd(n);
    check(n == 6, "R3", n, 6);
    check(dac_code == 8'd126, "R4", dac_code, 126);

    // R8 hold with enable low
    cur_req = "R8"; cal_en = 1'b0; v0 = dac_code;
    run(10);
    check(int'(dac_code) == v0, "R8", dac_code, v0);

    // R5 below target -> step up
    cur_req = "R5"; adc_code = 10'd20; cal_en = 1'b1;
    repeat (3) wait_upd(n);
    check(dac_code == 8'd129, "R5", dac_code, 129);

    // R6 equal -> unchanged, strobe still there
    cur_req = "R6"; adc_code = 10'd32;
    wait_upd(n);
    check(dac_upd == 1'b1, "R6", dac_upd, 1);
    check(dac_code == 8'd129, "R6", dac_code, 129);

    // R9 host write ignored while running, taken while idle
    cur_req = "R9"; host_load(200); run(2);
    check(dac_code == 8'd129, "R9", dac_code, 129);
    cal_en = 1'b0; run(1); host_load(3);
    check(dac_code == 8'd3, "R9", dac_code, 3);

    // R7 floor clamp
    cur_req = "R7"; adc_code = 10'd1000; cal_en = 1'b1;
    repeat (5) wait_upd(n);
    check(dac_code == 8'd0, "R7", dac_code, 0);
    cal_en = 1'b0; run(1); host_load(254);
    adc_code = 10'd0; cal_en = 1'b1;
    repeat (4) wait_upd(n);
    check(dac_code == 8'd255, "R7", dac_code, 255);

    // R8 abort mid-correction, restart takes 8 clocks again
    cur_req = "R8"; cal_en = 1'b0; run(1); host_load(100);
    adc_code = 10'd900; cal_en = 1'b1; run(5);
    cal_en = 1'b0; run(4);
    check(dac_code == 8'd100, "R8", dac_code, 100);
    cal_en = 1'b1;
    wait_upd(n);
    check(n == 7, "R8", n, 7);
    check(dac_code == 8'd99, "R8", dac_code, 99);

    // R10: reading only matters in phase 5; elsewhere present a high value
    cur_req = "R10";
    for (int k = 0; k < 60; k++) begin
      adc_code = (m_ph == 5) ? 10'd0 : 10'd1000;
      step();
    end
    check(dac_code == 8'd109, "R10", dac_code, 109);

    // R11: new target 500, reading 400 -> step up
    cur_req = "R11"; cal_en = 1'b0; adc_code = 10'd400;
    tgt_wr_en = 1'b1; tgt_wr_data = 10'd500; step(); tgt_wr_en = 1'b0;
    v0 = dac_code; cal_en = 1'b1;
    wait_upd(n);
    check(int'(dac_code) == v0 + 1, "R11", dac_code, v0 + 1);
    run(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule